// File: doc/BRIEF.md
# Configurable Logic Output Macrocell

This block is one output cell of a programmable logic device. It receives product-term signals from an AND array. It ORs a fixed set of native terms with any neighbour-owned terms that the cell is allowed to borrow and that the neighbour currently leaves free. A polarity bit can invert the sum. The result leaves the cell in one of two ways: directly as combinational logic, or through a storage element that acts as a D, T, JK or SR flip-flop according to two configuration bits.

The flip-flop clock is either a dedicated clock pin or a product term. The block samples the selected source on the system clock `clk_i` and advances only on a low-to-high change of that source. Preset comes from a product term. Clear is the OR of two product terms. Both override the flip-flop clock. A load strobe writes the cell's bit of an 8-bit word into the register. The cell's read lane substitutes the register value at the same bit position on a pass-through data bus. The selected output drives the pin and also feeds back to the array.

Top module: `logic_macrocell`

## Requirements
- R1: The term sum is the OR of all native terms and of each borrowed term whose enable bit and neighbour-free bit are both 1. A borrowed term that is disabled or not free contributes 0.
- R2: When `cfg_invert_i` is 1 the term sum is inverted before the output mux and before the flip-flop data input.
- R3: With `cfg_reg_out_i`=0, `pin_o` is the polarity-adjusted sum in the same cycle. With `cfg_reg_out_i`=1, `pin_o` is the register. `feedback_o` always equals `pin_o`.
- R4: `cfg_ff_type_i`=00 selects D mode. On a flop clock edge the register takes the polarity-adjusted sum. With no edge and no override it holds.
- R5: `cfg_ff_type_i`=01 selects T mode. On an edge the register toggles when the polarity-adjusted sum is 1.
- R6: `cfg_ff_type_i`=10 selects JK mode. J is the polarity-adjusted sum and K is `aux_pt_i`. On an edge: J=1 K=0 sets, J=0 K=1 clears, J=K=1 toggles, J=K=0 holds.
- R7: `cfg_ff_type_i`=11 selects SR mode. S is the polarity-adjusted sum and R is `aux_pt_i`. On an edge: S only sets, R only clears, and both or neither hold.
- R8: The selected flop clock source is sampled at each `clk_i` rising edge. `cfg_clk_sel_i`=0 selects `clkin_i` and 1 selects `clk_pt_i`. A flop clock edge is a sample of 1 whose previous sample was 0, and the register updates at that same `clk_i` edge. The unselected source has no effect.
- R9: If either bit of `clear_pt_i` is 1 at a `clk_i` edge, the register becomes 0 regardless of the flop clock, preset, load or mode.
- R10: If `preset_pt_i` is 1 and no clear is active at a `clk_i` edge, the register becomes 1.
- R11: If `load_i` is 1 and neither clear nor preset is active at a `clk_i` edge, the register takes `data_i[BIT_POS]` instead of its next state.
- R12: `rd_data_o` equals `data_i`, except that bit BIT_POS is replaced by the register value.
- R13: Reset (`rst_ni`=0) clears the register and records the last clock sample as 1. A clock source that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the flop clock source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| native_pt_i | input | NATIVE_PT | Native product terms |
| borrow_pt_i | input | BORROW_PT | Product terms owned by the neighbour cell |
| borrow_free_i | input | BORROW_PT | Neighbour leaves the matching term unused |
| cfg_borrow_en_i | input | BORROW_PT | Per-term borrow enable |
| cfg_invert_i | input | 1 | Invert the term sum |
| cfg_ff_type_i | input | 2 | 00 D, 01 T, 10 JK, 11 SR |
| cfg_reg_out_i | input | 1 | 1 registered output, 0 combinational |
| cfg_clk_sel_i | input | 1 | 0 clock pin, 1 product-term clock |
| clkin_i | input | 1 | Dedicated flop clock pin |
| clk_pt_i | input | 1 | Product-term flop clock |
| aux_pt_i | input | 1 | K or R input in JK and SR modes |
| preset_pt_i | input | 1 | Preset product term, active high |
| clear_pt_i | input | 2 | Clear product terms, either one active high |
| load_i | input | 1 | Load strobe |
| data_i | input | DATA_W | Load word and pass-through read bus |
| pin_o | output | 1 | Port pin output |
| feedback_o | output | 1 | Feedback to the AND array |
| rd_data_o | output | DATA_W | Read bus with this cell's bit substituted |

## Verification
The bench goes after priority among clear, preset, load and clock edges. A design that ranks preset above clear would drive the pin high while a clear term is active. It also checks borrowed terms that are enabled but not free: a design that ignores the free bit would show a sum of 1 on the combinational path. The JK toggle and the SR hold-on-both cases are exercised repeatedly, so a swapped decode shows up as a wrong registered pin. Clock edges on the unselected source, and a clock that is already high at reset release, are both driven. A design that edge-detects the wrong source or resets the sample low would update the register when it should hold.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ff_type_e;
endpackage

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
  parameter int NATIVE_PT = 6,
  parameter int BORROW_PT = 4
) (
  input  logic [NATIVE_PT-1:0] native_i,
  input  logic [BORROW_PT-1:0] borrow_i,
  input  logic [BORROW_PT-1:0] free_i,
  input  logic [BORROW_PT-1:0] en_i,
  input  logic                 invert_i,
  output logic                 sum_o
);
  logic [BORROW_PT-1:0] gated;

  for (genvar g = 0; g < BORROW_PT; g++) begin : g_borrow
    assign gated[g] = borrow_i[g] & free_i[g] & en_i[g];
  end

  assign sum_o = (|native_i | |gated) ^ invert_i;
endmodule

// File: rtl/mc_clk_edge.sv
module mc_clk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic pin_clk_i,
  input  logic pt_clk_i,
  output logic edge_o
);
  logic src, sample_q;

  assign src = sel_i ? pt_clk_i : pin_clk_i;

  // reset high: a source already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= 1'b1;
    else         sample_q <= src;
  end

  assign edge_o = src & ~sample_q;
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import macrocell_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ff_type_e ff_type_i,
  input  logic     edge_i,
  input  logic     d_i,
  input  logic     aux_i,
  input  logic     preset_i,
  input  logic     clear_i,
  input  logic     load_i,
  input  logic     load_bit_i,
  output logic     q_o
);
  logic q, nxt;

  always_comb begin
    unique case (ff_type_i)
      FF_D:  nxt = d_i;
      FF_T:  nxt = q ^ d_i;
      FF_JK: begin
        unique case ({d_i, aux_i})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~q;
          default: nxt = q;
        endcase
      end
      default: begin
        unique case ({d_i, aux_i})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= 1'b0;
    else if (clear_i)  q <= 1'b0;
    else if (preset_i) q <= 1'b1;
    else if (load_i)   q <= load_bit_i;
    else if (edge_i)   q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
  import macrocell_pkg::*;
#(
  parameter int NATIVE_PT = 6,
  parameter int BORROW_PT = 4,
  parameter int DATA_W    = 8,
  parameter int BIT_POS   = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NATIVE_PT-1:0] native_pt_i,
  input  logic [BORROW_PT-1:0] borrow_pt_i,
  input  logic [BORROW_PT-1:0] borrow_free_i,
  input  logic [BORROW_PT-1:0] cfg_borrow_en_i,
  input  logic                 cfg_invert_i,
  input  logic [1:0]           cfg_ff_type_i,
  input  logic                 cfg_reg_out_i,
  input  logic                 cfg_clk_sel_i,
  input  logic                 clkin_i,
  input  logic                 clk_pt_i,
  input  logic                 aux_pt_i,
  input  logic                 preset_pt_i,
  input  logic [1:0]           clear_pt_i,
  input  logic                 load_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 pin_o,
  output logic                 feedback_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic sum_p, ff_edge, ff_q, clear_any;

  assign clear_any = |clear_pt_i;

  mc_term_sum #(.NATIVE_PT(NATIVE_PT), .BORROW_PT(BORROW_PT)) u_sum (
    .native_i (native_pt_i),
    .borrow_i (borrow_pt_i),
    .free_i   (borrow_free_i),
    .en_i     (cfg_borrow_en_i),
    .invert_i (cfg_invert_i),
    .sum_o    (sum_p)
  );

  mc_clk_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cfg_clk_sel_i),
    .pin_clk_i (clkin_i),
    .pt_clk_i  (clk_pt_i),
    .edge_o    (ff_edge)
  );

  mc_storage u_ff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ff_type_i  (ff_type_e'(cfg_ff_type_i)),
    .edge_i     (ff_edge),
    .d_i        (sum_p),
    .aux_i      (aux_pt_i),
    .preset_i   (preset_pt_i),
    .clear_i    (clear_any),
    .load_i     (load_i),
    .load_bit_i (data_i[BIT_POS]),
    .q_o        (ff_q)
  );

  assign pin_o      = cfg_reg_out_i ? ff_q : sum_p;
  assign feedback_o = pin_o;

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == BIT_POS) begin : g_own
      assign rd_data_o[b] = ff_q;
    end else begin : g_pass
      assign rd_data_o[b] = data_i[b];
    end
  end
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic preset_i,
  input logic load_i,
  input logic load_bit_i,
  input logic edge_i,
  input logic q_i
);
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !q_i); // R9
  AST_PRESET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i && !clear_i |=> q_i); // R10
  AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !preset_i && !clear_i |=> q_i == $past(load_bit_i)); // R11
  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !preset_i && !load_i && !edge_i |=> $stable(q_i)); // R4
endmodule

bind logic_macrocell mc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_any),
  .preset_i   (preset_pt_i),
  .load_i     (load_i),
  .load_bit_i (data_i[BIT_POS]),
  .edge_i     (ff_edge),
  .q_i        (ff_q)
);

// File: tb/logic_macrocell_tb_top.sv
`timescale 1ns/1ps
module logic_macrocell_tb_top;
  localparam int NP = 6, BP = 4, DW = 8, BITP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] native = '0;
  logic [BP-1:0] borrow = '0, bfree = '0, ben = '0;
  logic inv = 0, reg_out = 0, clk_sel = 0, clkin = 0, clkpt = 0, aux = 0;
  logic preset = 0, load = 0;
  logic [1:0] ff_type = 2'b00, clear = 2'b00;
  logic [DW-1:0] data = '0;
  logic pin, fb;
  logic [DW-1:0] rd;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R13";

  always #2.5 clk = ~clk;

  logic_macrocell #(.NATIVE_PT(NP), .BORROW_PT(BP), .DATA_W(DW), .BIT_POS(BITP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .native_pt_i(native), .borrow_pt_i(borrow),
    .borrow_free_i(bfree), .cfg_borrow_en_i(ben), .cfg_invert_i(inv),
    .cfg_ff_type_i(ff_type), .cfg_reg_out_i(reg_out), .cfg_clk_sel_i(clk_sel),
    .clkin_i(clkin), .clk_pt_i(clkpt), .aux_pt_i(aux), .preset_pt_i(preset),
    .clear_pt_i(clear), .load_i(load), .data_i(data), .pin_o(pin),
    .feedback_o(fb), .rd_data_o(rd));

  // behavioural reference
  bit mq = 0, mclk = 1;
  function automatic bit model_sum();
    bit s = 0;
    for (int i = 0; i < NP; i++) if (native[i]) s = 1;
    for (int i = 0; i < BP; i++) if (borrow[i] && bfree[i] && ben[i]) s = 1;
    return s ^ inv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mq = 0; mclk = 1; end
    else begin
      bit src, edg, s;
      src = clk_sel ? clkpt : clkin;
      edg = src && !mclk;
      mclk = src;
      s = model_sum();
      if (clear != 0) mq = 0;
      else if (preset) mq = 1;
      else if (load) mq = data[BITP];
      else if (edg) begin
        case (ff_type)
          2'b00: mq = s;
          2'b01: mq = mq ^ s;
          2'b10: mq = (s && aux) ? !mq : (s ? 1 : (aux ? 0 : mq));
          default: mq = (s && !aux) ? 1 : ((!s && aux) ? 0 : mq);
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ep;
    logic [DW-1:0] er;
    ep = reg_out ? mq : model_sum();
    er = data; er[BITP] = mq;
    check(cur_req, pin, ep);
    check({cur_req, "/R3"}, fb, ep);
    check({cur_req, "/R12"}, rd, er);
  endtask

  task automatic run_phase(string tag, int n, logic [1:0] ty, bit ro, bit cs, int p_ctl);
    cur_req = tag;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      ff_type = ty; reg_out = ro; clk_sel = cs;
      native = NP'($urandom & $urandom & $urandom);
      borrow = BP'($urandom); bfree = BP'($urandom); ben = BP'($urandom);
      inv = 1'($urandom); aux = 1'($urandom);
      clkin = 1'($urandom); clkpt = 1'($urandom);
      data = DW'($urandom);
      preset = ($urandom_range(99) < p_ctl);
      clear = ($urandom_range(99) < p_ctl) ? 2'($urandom_range(3, 1)) : 2'b00;
      load = ($urandom_range(99) < p_ctl);
    end
  endtask

  initial begin
    // R13: clock pin high through reset, D=1, registered output
    ff_type = 2'b00; reg_out = 1; clkin = 1; native = '1;
    repeat (3) @(negedge clk);
    check("R13", pin, 1'b0);
    rst_n = 1;
    repeat (3) begin @(negedge clk); check("R13", pin, 1'b0); end
    clkin = 0; @(negedge clk); clkin = 1; @(negedge clk);
    check("R13/R4", pin, 1'b1);

    run_phase("R1", 300, 2'b00, 0, 0, 0);
    run_phase("R2", 300, 2'b01, 0, 1, 0);
    run_phase("R4", 400, 2'b00, 1, 0, 0);
    run_phase("R5", 400, 2'b01, 1, 0, 0);
    run_phase("R6", 600, 2'b10, 1, 0, 0);
    run_phase("R7", 600, 2'b11, 1, 1, 0);
    run_phase("R8", 400, 2'b01, 1, 1, 0);
    run_phase("R8", 400, 2'b10, 1, 0, 0);
    run_phase("R9", 400, 2'b01, 1, 0, 40);
    run_phase("R10", 400, 2'b10, 1, 1, 25);
    run_phase("R11", 400, 2'b11, 1, 0, 15);
    run_phase("R3", 400, 2'b10, 0, 0, 10);
    @(negedge clk); compare_all();

    // directed: clear and preset together
    cur_req = "R9";
    reg_out = 1; preset = 1; clear = 2'b10; load = 1; data = '1;
    @(negedge clk); check("R9", pin, 1'b0); compare_all();
    preset = 0; clear = 0; load = 0;
    @(negedge clk); compare_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule